// File: doc/BRIEF.md
# Multi-Cell Lithium-Ion Voltage Guard

This controller protects a series stack of three or four lithium-ion cells. It drives a multiplexed cell sampler through a cell-select output and scans the cells without stopping. For each selected cell it reads back a digitized voltage code and an open-connection flag. It compares each code against four thresholds: an overcharge set level, an overcharge release level, an undercharge set level and an undercharge release level. From these comparisons it drives enables for an external charge FET and an external discharge FET, and it reports a sleep state.

A fault is acted on only after it has been seen in a set number of consecutive complete scans. One clean scan restarts the count. An overcharged cell turns the charge path off until every cell is back below the release level. While the stack is in that hysteresis band, a discharge-current flag from the sense resistor re-enables the charge FET, so that load current does not flow through its body diode. An undercharged cell turns both FETs off and puts the controller to sleep, which also freezes the scan. A wake-up input that reports a charger leaves sleep. The discharge FET then stays off until every cell has recovered past the undercharge release level. The scan rate and the qualification length are parameters of a prescaled system clock.

Top module: `cell_guard_top`

## Requirements
- R1: The controller selects a new cell every PRE_DIV clock cycles on `cell_sel`, counting up from 0 and wrapping after the last active cell. A scan is complete when the last active cell has been sampled.
- R2: When `cell3_mode` is 1, only cells 0..2 are selected, and the code present for cell 3 has no effect on any output. When it is 0, cells 0..3 are used.
- R3: In normal state, if QUAL_SCANS consecutive scans each contain a cell whose code is above OV_SET, `chg_en` goes low at the end of the last of those scans and `dsg_en` stays high. A scan with no such cell restarts the count.
- R4: After an overcharge trip, the charge path stays blocked until the end of a scan in which every cell code is below OV_CLR and no cell is flagged open. A code between OV_CLR and OV_SET keeps it blocked.
- R5: While blocked for overcharge, `chg_en` follows `dsg_sense`: high when the discharge-current flag is 1, low when it is 0. The change appears in the same cycle.
- R6: In normal or overcharge state, if QUAL_SCANS consecutive scans each contain a cell whose code is below UV_SET, the controller drives `chg_en` and `dsg_en` low and `sleep` high, and `cell_sel` stops changing.
- R7: Sleep is left only while `wake` is 1. After wake, `chg_en` is allowed but `dsg_en` stays low until the end of a scan in which every cell code is above UV_CLR. After that scan the controller returns to normal state.
- R8: `chg_en` is low whenever `chg_allow` is 0.
- R9: A cell with `cell_open` set counts as above OV_SET, so charging is blocked once it qualifies.
- R10: After reset, `cell_sel` is 0, `sleep` is 0, and both FET enables stay low until the end of the first complete scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cell3_mode | input | 1 | 1 selects three-cell operation, 0 selects four cells |
| cell_code | input | CODE_W | Digitized voltage of the cell selected by cell_sel |
| cell_open | input | 1 | Sense connection of the selected cell is open |
| chg_allow | input | 1 | Charge enable permission |
| wake | input | 1 | Charger presence indication |
| dsg_sense | input | 1 | Sense-resistor drop shows discharge current |
| cell_sel | output | 2 | Cell index presented to the sampler |
| chg_en | output | 1 | Charge FET enable |
| dsg_en | output | 1 | Discharge FET enable |
| sleep | output | 1 | Controller is in undercharge sleep |

## Verification
The stack is driven with all cells at nominal level, with an overcharge lasting only one scan, and with an overcharge held for several scans. This separates restarting the qualification from acting on a fault. Codes held inside the two hysteresis bands show that the set and release levels are kept apart. An undercharge placed on cell 3 in three-cell mode, next to the same fault on cell 0 in four-cell mode, shows whether the cell count masks that position. Toggling the discharge-current flag, the charge permission and wake in each state shows which state each input acts on.

// File: rtl/cell_guard_pkg.sv
package cell_guard_pkg;
  typedef enum logic [1:0] {
    CG_NORM  = 2'd0,
    CG_OVER  = 2'd1,
    CG_SLEEP = 2'd2,
    CG_RECOV = 2'd3
  } cg_state_e;

  typedef struct packed {
    logic any_ov;
    logic all_ov_clr;
    logic any_uv;
    logic all_uv_clr;
  } cg_scan_t;
endpackage

// File: rtl/cg_scan_timer.sv
module cg_scan_timer #(
  parameter int PRE_DIV   = 8,
  parameter int CELLS_MAX = 4,
  localparam int PC_W  = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1,
  localparam int SEL_W = $clog2(CELLS_MAX)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             halt,
  input  logic             cell3_mode,
  output logic [SEL_W-1:0] sel,
  output logic             tick,
  output logic             first,
  output logic             last
);
  logic [PC_W-1:0]  pc_q, pc_d;
  logic [SEL_W-1:0] sel_q, sel_d;
  logic [SEL_W-1:0] last_idx;

  assign last_idx = cell3_mode ? SEL_W'(CELLS_MAX - 2) : SEL_W'(CELLS_MAX - 1);
  assign tick  = !halt && (pc_q == PC_W'(PRE_DIV - 1));
  assign last  = (sel_q >= last_idx);
  assign first = (sel_q == '0);
  assign sel   = sel_q;

  always_comb begin
    pc_d  = pc_q;
    sel_d = sel_q;
    if (!halt) begin
      pc_d = tick ? '0 : pc_q + 1'b1;
    end
    if (tick) begin
      sel_d = last ? '0 : sel_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      sel_q <= '0;
    end else begin
      pc_q  <= pc_d;
      sel_q <= sel_d;
    end
  end

  assert_halt_freezes_sel_R6: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> $stable(sel_q));
endmodule

// File: rtl/cg_cell_cmp.sv
module cg_cell_cmp
  import cell_guard_pkg::*;
#(
  parameter int CODE_W = 12,
  parameter int OV_SET = 2100,
  parameter int OV_CLR = 2000,
  parameter int UV_SET = 1150,
  parameter int UV_CLR = 1300
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              first,
  input  logic [CODE_W-1:0] code,
  input  logic              open_wire,
  output cg_scan_t          scan
);
  cg_scan_t acc_q, cur;

  always_comb begin
    cur.any_ov     = open_wire || (code > CODE_W'(OV_SET));
    cur.all_ov_clr = !open_wire && (code < CODE_W'(OV_CLR));
    cur.any_uv     = (code < CODE_W'(UV_SET));
    cur.all_uv_clr = (code > CODE_W'(UV_CLR));
    if (first) begin
      scan = cur;
    end else begin
      scan.any_ov     = acc_q.any_ov     || cur.any_ov;
      scan.all_ov_clr = acc_q.all_ov_clr && cur.all_ov_clr;
      scan.any_uv     = acc_q.any_uv     || cur.any_uv;
      scan.all_uv_clr = acc_q.all_uv_clr && cur.all_uv_clr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (tick) begin
      acc_q <= scan;
    end
  end
endmodule

// File: rtl/cg_qualifier.sv
module cg_qualifier #(
  parameter int QUAL_SCANS = 2,
  localparam int CNT_W = $clog2(QUAL_SCANS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic scan_done,
  input  logic cond,
  output logic fire
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign fire = arm && scan_done && cond && (cnt_q == CNT_W'(QUAL_SCANS - 1));

  always_comb begin
    cnt_d = cnt_q;
    if (!arm) begin
      cnt_d = '0;
    end else if (scan_done) begin
      cnt_d = (cond && !fire) ? cnt_q + 1'b1 : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CNT_W'(QUAL_SCANS));
endmodule

// File: rtl/cell_guard_top.sv
module cell_guard_top
  import cell_guard_pkg::*;
#(
  parameter int CODE_W     = 12,
  parameter int PRE_DIV    = 8,
  parameter int QUAL_SCANS = 2,
  parameter int OV_SET     = 2100,
  parameter int OV_CLR     = 2000,
  parameter int UV_SET     = 1150,
  parameter int UV_CLR     = 1300
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cell3_mode,
  input  logic [CODE_W-1:0] cell_code,
  input  logic              cell_open,
  input  logic              chg_allow,
  input  logic              wake,
  input  logic              dsg_sense,
  output logic [1:0]        cell_sel,
  output logic              chg_en,
  output logic              dsg_en,
  output logic              sleep
);
  localparam int NQ = 2;  // 0: overcharge, 1: undercharge

  cg_state_e st_q, st_d;
  logic      init_q, init_d;
  logic      tick, first, last, scan_done;
  cg_scan_t  scan;
  logic [NQ-1:0] q_arm, q_cond, q_fire;
  logic      ov_fire, uv_fire;

  cg_scan_timer #(.PRE_DIV(PRE_DIV), .CELLS_MAX(4)) u_timer (
    .clk(clk), .rst_n(rst_n), .halt(st_q == CG_SLEEP), .cell3_mode(cell3_mode),
    .sel(cell_sel), .tick(tick), .first(first), .last(last));

  cg_cell_cmp #(.CODE_W(CODE_W), .OV_SET(OV_SET), .OV_CLR(OV_CLR),
                .UV_SET(UV_SET), .UV_CLR(UV_CLR)) u_cmp (
    .clk(clk), .rst_n(rst_n), .tick(tick), .first(first),
    .code(cell_code), .open_wire(cell_open), .scan(scan));

  assign scan_done = tick && last;
  assign q_arm  = {(st_q == CG_NORM) || (st_q == CG_OVER), (st_q == CG_NORM)};
  assign q_cond = {scan.any_uv, scan.any_ov};

  for (genvar g = 0; g < NQ; g++) begin : g_qual
    cg_qualifier #(.QUAL_SCANS(QUAL_SCANS)) u_q (
      .clk(clk), .rst_n(rst_n), .arm(q_arm[g]), .scan_done(scan_done),
      .cond(q_cond[g]), .fire(q_fire[g]));
  end

  assign ov_fire = q_fire[0];
  assign uv_fire = q_fire[1];

  always_comb begin
    st_d   = st_q;
    init_d = init_q || scan_done;
    unique case (st_q)
      CG_NORM:  if (uv_fire) st_d = CG_SLEEP;
                else if (ov_fire) st_d = CG_OVER;
      CG_OVER:  if (uv_fire) st_d = CG_SLEEP;
                else if (scan_done && scan.all_ov_clr) st_d = CG_NORM;
      CG_SLEEP: if (wake) st_d = CG_RECOV;
      CG_RECOV: if (scan_done && scan.all_uv_clr) st_d = CG_NORM;
      default:  st_d = CG_NORM;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= CG_NORM;
      init_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      init_q <= init_d;
    end
  end

  assign chg_en = init_q && chg_allow &&
                  ((st_q == CG_NORM) || (st_q == CG_RECOV) ||
                   ((st_q == CG_OVER) && dsg_sense));
  assign dsg_en = init_q && ((st_q == CG_NORM) || (st_q == CG_OVER));
  assign sleep  = (st_q == CG_SLEEP);

  assert_sleep_after_scan_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleep) |-> $past(scan_done));
  assert_release_on_scan_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(st_q == CG_OVER) |-> $past(scan_done));
  assert_wake_needed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == CG_SLEEP) |=> (st_q == CG_SLEEP) || $past(wake));
  assert_first_scan_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_q) |-> $past(tick));
endmodule

// File: tb/tb_cell_guard_top.sv
module tb_cell_guard_top;
  localparam int PRE  = 8;
  localparam int QUAL = 2;
  localparam int OVS = 2100, OVC = 2000, UVS = 1150, UVC = 1300;
  localparam int SCAN4 = 4 * PRE;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cell3_mode = 1'b0, chg_allow = 1'b1, wake = 1'b0, dsg_sense = 1'b0;
  logic [11:0] cv [4];
  logic        opn [4];
  logic [11:0] cell_code;
  logic        cell_open;
  logic [1:0]  cell_sel;
  logic        chg_en, dsg_en, sleep;

  int n_chk = 0, n_bad = 0, sel3_seen = 0;

  always #2.5 clk = ~clk;

  assign cell_code = cv[cell_sel];
  assign cell_open = opn[cell_sel];

  cell_guard_top dut (
    .clk(clk), .rst_n(rst_n), .cell3_mode(cell3_mode), .cell_code(cell_code),
    .cell_open(cell_open), .chg_allow(chg_allow), .wake(wake), .dsg_sense(dsg_sense),
    .cell_sel(cell_sel), .chg_en(chg_en), .dsg_en(dsg_en), .sleep(sleep));

  // behavioural reference: m_st 0 normal, 1 overcharge, 2 sleep, 3 recovering
  int m_pc, m_idx, m_st, m_ovn, m_uvn;
  bit m_init, a_ov, a_oc, a_uv, a_uc;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pc = 0; m_idx = 0; m_st = 0; m_ovn = 0; m_uvn = 0; m_init = 0;
      a_ov = 0; a_oc = 0; a_uv = 0; a_uc = 0;
    end else begin
      int ncell, code, nst;
      bit tk, dn, o, c, u, r, s_ov, s_oc, s_uv, s_uc, fov, fuv;
      ncell = cell3_mode ? 3 : 4;
      tk = (m_st != 2) && (m_pc == PRE - 1);
      code = int'(cv[m_idx]);
      o = opn[m_idx] || code > OVS;
      c = !opn[m_idx] && code < OVC;
      u = code < UVS;
      r = code > UVC;
      if (m_idx == 0) begin s_ov = o; s_oc = c; s_uv = u; s_uc = r; end
      else begin s_ov = a_ov | o; s_oc = a_oc & c; s_uv = a_uv | u; s_uc = a_uc & r; end
      dn = tk && (m_idx >= ncell - 1);
      fov = dn && s_ov && m_st == 0 && m_ovn == QUAL - 1;
      fuv = dn && s_uv && m_st <= 1 && m_uvn == QUAL - 1;
      nst = m_st;
      if (m_st <= 1 && fuv) nst = 2;
      else if (m_st == 0 && fov) nst = 1;
      else if (m_st == 1 && dn && s_oc) nst = 0;
      else if (m_st == 2 && wake) nst = 3;
      else if (m_st == 3 && dn && s_uc) nst = 0;
      if (m_st != 0) m_ovn = 0; else if (dn) m_ovn = (s_ov && !fov) ? m_ovn + 1 : 0;
      if (m_st > 1) m_uvn = 0; else if (dn) m_uvn = (s_uv && !fuv) ? m_uvn + 1 : 0;
      if (tk) begin a_ov = s_ov; a_oc = s_oc; a_uv = s_uv; a_uc = s_uc; end
      if (m_st != 2) m_pc = tk ? 0 : m_pc + 1;
      if (tk) m_idx = dn ? 0 : m_idx + 1;
      if (dn) m_init = 1;
      m_st = nst;
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (rst_n) begin
      bit e_chg;
      e_chg = m_init && chg_allow && (m_st == 0 || m_st == 3 || (m_st == 1 && dsg_sense));
      chk("R1 cell_sel", int'(cell_sel), m_idx);
      chk("R3 chg_en", int'(chg_en), int'(e_chg));
      chk("R6 dsg_en", int'(dsg_en), int'(m_init && m_st <= 1));
      chk("R7 sleep", int'(sleep), int'(m_st == 2));
      if (cell3_mode && cell_sel == 2'd3) sel3_seen++;
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_all(int v);
    for (int i = 0; i < 4; i++) begin cv[i] = 12'(v); opn[i] = 1'b0; end
  endtask

  initial begin
    #(5 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [1:0] held;
    set_all(1850);
    cyc(3);
    rst_n = 1'b1;
    // R10: reset state, FETs off until the first scan finishes
    chk("R10 sel", int'(cell_sel), 0);
    chk("R10 sleep", int'(sleep), 0);
    cyc(SCAN4 - 4);
    chk("R10 chg before scan", int'(chg_en), 0);
    chk("R10 dsg before scan", int'(dsg_en), 0);
    cyc(8);
    chk("R10 chg after scan", int'(chg_en), 1);
    chk("R10 dsg after scan", int'(dsg_en), 1);

    // R3: overcharge lasting one scan is not acted on
    cv[2] = 12'd2150; cyc(SCAN4); cv[2] = 12'd1850; cyc(2 * SCAN4);
    chk("R3 short fault", int'(chg_en), 1);
    // R3: sustained overcharge trips charge only
    cv[2] = 12'd2150; cyc(3 * SCAN4);
    chk("R3 trip chg", int'(chg_en), 0);
    chk("R3 dsg kept", int'(dsg_en), 1);
    // R5: discharge current re-enables the charge FET
    dsg_sense = 1'b1; cyc(1);
    chk("R5 sense on", int'(chg_en), 1);
    dsg_sense = 1'b0; cyc(1);
    chk("R5 sense off", int'(chg_en), 0);
    // R4: inside the band stays blocked, below release clears
    cv[2] = 12'd2050; cyc(3 * SCAN4);
    chk("R4 in band", int'(chg_en), 0);
    cv[2] = 12'd1950; cyc(2 * SCAN4);
    chk("R4 released", int'(chg_en), 1);
    // R9: open sense connection blocks charging
    opn[1] = 1'b1; cyc(3 * SCAN4);
    chk("R9 open blocks", int'(chg_en), 0);
    opn[1] = 1'b0; cyc(2 * SCAN4);
    chk("R9 open cleared", int'(chg_en), 1);
    // R8: charge permission gates chg_en
    chg_allow = 1'b0; cyc(1);
    chk("R8 gate", int'(chg_en), 0);
    chg_allow = 1'b1; cyc(1);
    chk("R8 restore", int'(chg_en), 1);
    // R2: three-cell mode ignores cell 3
    cell3_mode = 1'b1; cyc(SCAN4);
    sel3_seen = 0;
    cv[3] = 12'd1000; cyc(4 * SCAN4);
    chk("R2 cell3 ignored dsg", int'(dsg_en), 1);
    chk("R2 cell3 ignored sleep", int'(sleep), 0);
    chk("R2 no sel 3", sel3_seen, 0);
    cv[3] = 12'd1850; cell3_mode = 1'b0; cyc(2 * SCAN4);
    // R6: undercharge sleeps and freezes the scan
    cv[0] = 12'd1000; cyc(3 * SCAN4);
    chk("R6 sleep", int'(sleep), 1);
    chk("R6 chg off", int'(chg_en), 0);
    chk("R6 dsg off", int'(dsg_en), 0);
    held = cell_sel; cyc(50);
    chk("R6 scan frozen", int'(cell_sel), int'(held));
    // R7: wake, discharge stays off until recovery above release
    cv[0] = 12'd1250; cyc(20);
    chk("R7 no wake stays asleep", int'(sleep), 1);
    wake = 1'b1; cyc(2); wake = 1'b0; cyc(1);
    chk("R7 woken", int'(sleep), 0);
    chk("R7 chg allowed", int'(chg_en), 1);
    cyc(3 * SCAN4);
    chk("R7 dsg held off", int'(dsg_en), 0);
    cv[0] = 12'd1350; cyc(2 * SCAN4);
    chk("R7 dsg back", int'(dsg_en), 1);
    cyc(4);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule